// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave for a Three-Channel Video Filter

This block is the control port of a three-channel analog video filter front end. It listens on a two-wire I2C bus, and it oversamples both lines with the system clock. It accepts only write frames. A frame carries three bytes: a device address, a register selector and one data byte. The block acknowledges by pulling SDA low through an open-drain enable. It answers only when the address is its own and the selector names one of its three registers. After a good frame it commits the data byte to the selected register.

The device address is one of three values. A three-state strap, presented as a 2-bit code, picks the value, and the block resolves it once after reset. Every register write needs a complete frame, because the selector does not advance after the data byte. The stored fields go out as decoded per-channel controls: a cutoff code, an input coupling kind for each channel, half-cutoff flags for the second and third channels, bypass, power-down, and an input-B select. The input-B select also follows an external pin.

Top module: `vfe_ctl_slave`

## Requirements
- R1: After a synchronous active-low reset the cutoff code is 7Dh, every channel input kind is clamp (00), and power-down, bypass and all half-cutoff flags are 0. The input-B select then follows only the external pin.
- R2: The block resolves its 8-bit address byte from the strap code at reset: 00 gives 90h, 01 gives 92h, 10 or 11 gives 94h. It drives the ACK slot low only for that exact byte. An address byte with LSB 1 (a read) or any other value gets no ACK.
- R3: Only selector values 01h, 02h and 03h are acknowledged. Any other selector gets no ACK, and no register changes.
- R4: After an acknowledged address and selector, the data byte is always acknowledged, whatever its value.
- R5: Selector 01h stores the whole data byte as the 8-bit cutoff code (bit 7 range flag, bits 6:0 step).
- R6: Selector 02h stores three 2-bit input-kind fields: channel 1 in data bits 7:6, channel 2 in bits 5:4, channel 3 in bits 3:2. Field 00 means clamp and comes out as 00. Field 01 means bias and comes out as 01. Field 1x means direct and comes out as 10, so the low bit is ignored. The output carries channel 1 in bits 1:0, channel 2 in bits 3:2 and channel 3 in bits 5:4. Data bits 1:0 have no effect.
- R7: Selector 03h stores power-down from data bit 7, the mux flag from bit 6, half-cutoff from bit 5 and bypass from bit 4. Bits 3:0 have no effect.
- R8: The input-B select is high when the external pin is high or the stored mux flag is set. It is low only when both are low.
- R9: The channel 1 half-cutoff flag is always 0. The channel 2 and channel 3 flags equal the stored half-cutoff bit while bypass is clear, and both are 0 while bypass is set.
- R10: A start or stop condition that arrives before the data byte's ACK slot abandons the frame, and no register changes. A new start always begins a fresh frame.
- R11: A byte sent after the acknowledged data byte, before a stop, gets no ACK and writes nothing.
- R12: A committed setting appears on the outputs before the data byte's ACK clock has finished.
- R13: A change of the strap code after reset does not change the address the block answers to, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least about 20 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain acknowledge) |
| strap_i | input | 2 | Address strap code: 00 low, 01 high, 1x open |
| mux_pin_i | input | 1 | External input-B request pin |
| cutoff_code_o | output | 8 | Stored 256-step cutoff code |
| ch_type_o | output | 6 | Per-channel input kind, 2 bits each, channel 1 in the low pair |
| ch_half_o | output | 3 | Per-channel half-cutoff flag, channel 1 in bit 0 |
| filt_bypass_o | output | 1 | Filter bypass |
| pwr_down_o | output | 1 | Analog power-down |
| sel_b_o | output | 1 | Effective input-B select for all channels |

## Verification
The bench goes after the acknowledge decisions at each byte position. A slave that compared only seven address bits would acknowledge a read address. One that checked the selector loosely would acknowledge 00h or 04h and might corrupt a register. The bench also cuts frames short with a stop or a repeated start partway through the data byte; a design that committed early would show the partial byte on the outputs. Other targets are a trailing fourth byte, which an auto-incrementing design would acknowledge and store; bypass masking the half-cutoff flags; the direct-code low bit; and a strap changed after reset, which a continuously decoding address would follow.

// File: rtl/vfe_ctl_pkg.sv
// Package: shared types and constants for the video filter control slave.
// Assumes a fixed three-channel register layout.
package vfe_ctl_pkg;

    localparam int CH_COUNT    = 3;
    localparam int KIND_W      = 2;
    localparam int CUT_W       = 8;
    localparam logic [4:0] ADDR_HI = 5'b10010;

    typedef enum logic [1:0] {
        KIND_CLAMP  = 2'b00,
        KIND_BIAS   = 2'b01,
        KIND_DIRECT = 2'b10
    } in_kind_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_BITS = 2'd1,
        ENG_ACK  = 2'd2,
        ENG_HOLD = 2'd3
    } eng_state_e;

    // Map the three-state strap code to the 7-bit device address
    function automatic logic [6:0] strap_to_addr(input logic [1:0] code);
        logic [1:0] low;
        if (code[1])           low = 2'b10;
        else if (code[0])      low = 2'b01;
        else                   low = 2'b00;
        return {ADDR_HI, low};
    endfunction

endpackage

// File: rtl/vfe_i2c_sync.sv
// Module: brings SCL and SDA into the clock domain and flags bus events.
// Assumes clk is much faster than SCL; STAGES must be at least 2.
module vfe_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_in;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] line_q;

    assign raw_in = {sda_i, scl_i};

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            logic [STAGES-1:0] chain;
            // Shift the pad value through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw_in[l]};
            end
            assign line_s[l] = chain[STAGES-1];
        end
    endgenerate

    // Keep the previous synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '1;
        else        line_q <= line_s;
    end

    assign sda_s    = line_s[1];
    assign scl_rise = line_s[0] & ~line_q[0];
    assign scl_fall = ~line_s[0] & line_q[0];
    assign start_p  = line_s[0] & line_q[0] & line_q[1] & ~line_s[1];
    assign stop_p   = line_s[0] & line_q[0] & ~line_q[1] & line_s[1];

endmodule

// File: rtl/vfe_i2c_wr_engine.sv
// Module: frame engine for address, selector and data bytes.
// Drives the ACK and raises one write strobe per good frame.
// Assumes synchronized event pulses from vfe_i2c_sync.
module vfe_i2c_wr_engine
    import vfe_ctl_pkg::*;
#(
    parameter int BYTE_BITS = 8,
    parameter int FRAME_LEN = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_p,
    input  logic                 stop_p,
    input  logic [6:0]           dev_addr,
    output logic                 sda_oe,
    output logic                 wr_stb,
    output logic [1:0]           wr_sub,
    output logic [BYTE_BITS-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

    eng_state_e           state;
    logic [CNT_W-1:0]     bit_cnt;
    logic [IDX_W-1:0]     byte_idx;
    logic [BYTE_BITS-1:0] shreg;
    logic [1:0]           sub_q;
    logic                 byte_ok;

    // Decide whether the byte just received earns an acknowledge
    always_comb begin
        case (byte_idx)
            IDX_W'(0): byte_ok = (shreg == {dev_addr, 1'b0});
            IDX_W'(1): byte_ok = (shreg == 8'h01) || (shreg == 8'h02) || (shreg == 8'h03);
            LAST:      byte_ok = 1'b1;
            default:   byte_ok = 1'b0;
        endcase
    end

    // Frame sequencing, bit capture, ACK drive and commit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            sub_q    <= '0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (start_p) begin
                state    <= ENG_BITS;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_p) begin
                state  <= ENG_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ENG_BITS: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            shreg   <= {shreg[BYTE_BITS-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            if (byte_ok) begin
                                sda_oe <= 1'b1;
                                state  <= ENG_ACK;
                                if (byte_idx == IDX_W'(1)) sub_q  <= shreg[1:0];
                                if (byte_idx == LAST)      wr_stb <= 1'b1;
                            end else begin
                                state <= ENG_IDLE;
                            end
                        end
                    end
                    ENG_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            if (byte_idx == LAST) begin
                                state <= ENG_HOLD;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                                state    <= ENG_BITS;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_sub  = sub_q;
    assign wr_data = shreg;

endmodule

// File: rtl/vfe_cfg_regs.sv
// Module: the three configuration registers and their per-channel decode.
// Assumes wr_sub is 1, 2 or 3 whenever wr_stb is high.
module vfe_cfg_regs
    import vfe_ctl_pkg::*;
#(
    parameter logic [CUT_W-1:0] DEF_CUTOFF = 8'h7D
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  logic [1:0]                 wr_sub,
    input  logic [7:0]                 wr_data,
    input  logic                       mux_pin,
    output logic [CUT_W-1:0]           cutoff_code,
    output logic [CH_COUNT*KIND_W-1:0] ch_type,
    output logic [CH_COUNT-1:0]        ch_half,
    output logic                       filt_bypass,
    output logic                       pwr_down,
    output logic                       sel_b
);
    logic [CUT_W-1:0]           cut_q;
    logic [CH_COUNT*KIND_W-1:0] kind_q;
    logic                       pd_q, mux_q, half_q, byp_q;

    // Commit the data byte into the selected register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cut_q  <= DEF_CUTOFF;
            kind_q <= '0;
            pd_q   <= 1'b0;
            mux_q  <= 1'b0;
            half_q <= 1'b0;
            byp_q  <= 1'b0;
        end else if (wr_stb) begin
            case (wr_sub)
                2'd1: cut_q  <= wr_data;
                2'd2: kind_q <= wr_data[7:8-CH_COUNT*KIND_W];
                2'd3: begin
                    pd_q   <= wr_data[7];
                    mux_q  <= wr_data[6];
                    half_q <= wr_data[5];
                    byp_q  <= wr_data[4];
                end
                default: ;
            endcase
        end
    end

    generate
        for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
            localparam int HI = CH_COUNT*KIND_W - 1 - c*KIND_W;
            in_kind_e kind;
            // Decode the stored field; direct ignores the low bit
            always_comb begin
                if (kind_q[HI])        kind = KIND_DIRECT;
                else if (kind_q[HI-1]) kind = KIND_BIAS;
                else                   kind = KIND_CLAMP;
            end
            assign ch_type[c*KIND_W +: KIND_W] = kind;
            if (c == 0) begin : g_full
                assign ch_half[c] = 1'b0;
            end else begin : g_halved
                assign ch_half[c] = half_q & ~byp_q;
            end
        end
    endgenerate

    assign cutoff_code = cut_q;
    assign filt_bypass = byp_q;
    assign pwr_down    = pd_q;
    assign sel_b       = mux_pin | mux_q;

endmodule

// File: rtl/vfe_ctl_slave.sv
// Module: top of the write-only configuration slave.
// Resolves the strap once after reset, then ties sync, engine and registers.
// Assumes clk is at least about 20x SCL and strap_i is settled at reset.
module vfe_ctl_slave
    import vfe_ctl_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [CUT_W-1:0] DEF_CUTOFF  = 8'h7D
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    input  logic [1:0]                 strap_i,
    input  logic                       mux_pin_i,
    output logic [CUT_W-1:0]           cutoff_code_o,
    output logic [CH_COUNT*KIND_W-1:0] ch_type_o,
    output logic [CH_COUNT-1:0]        ch_half_o,
    output logic                       filt_bypass_o,
    output logic                       pwr_down_o,
    output logic                       sel_b_o
);
    logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [6:0] dev_addr;
    logic       addr_lat;
    logic       wr_stb;
    logic [1:0] wr_sub;
    logic [7:0] wr_data;

    // Latch the strap-derived address in the first cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lat <= 1'b0;
            dev_addr <= strap_to_addr(2'b00);
        end else if (!addr_lat) begin
            addr_lat <= 1'b1;
            dev_addr <= strap_to_addr(strap_i);
        end
    end

    vfe_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    vfe_i2c_wr_engine u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
        .dev_addr(dev_addr), .sda_oe(sda_oe_o), .wr_stb(wr_stb),
        .wr_sub(wr_sub), .wr_data(wr_data)
    );

    vfe_cfg_regs #(.DEF_CUTOFF(DEF_CUTOFF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sub(wr_sub),
        .wr_data(wr_data), .mux_pin(mux_pin_i), .cutoff_code(cutoff_code_o),
        .ch_type(ch_type_o), .ch_half(ch_half_o), .filt_bypass(filt_bypass_o),
        .pwr_down(pwr_down_o), .sel_b(sel_b_o)
    );

endmodule

// File: rtl/vfe_ctl_slave_chk.sv
// Module: property checker bound to vfe_ctl_slave.
// Relates the ACK drive, the commit strobe and the outputs over time.
module vfe_ctl_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       wr_stb,
    input logic [1:0] wr_sub,
    input logic [7:0] cutoff_code_o,
    input logic [5:0] ch_type_o,
    input logic [2:0] ch_half_o,
    input logic       filt_bypass_o,
    input logic       pwr_down_o
);
    // Reset state loads the defaults
    assert_reset_defaults_R1: assert property (@(posedge clk)
        !rst_n |=> (cutoff_code_o == 8'h7D && ch_type_o == 6'd0 &&
                    ch_half_o == 3'd0 && !filt_bypass_o && !pwr_down_o));

    // ACK drive starts only while SCL is low
    assert_ack_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // ACK drive is released only while SCL is low
    assert_ack_release_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_i);

    // A commit only targets one of the three registers
    assert_commit_valid_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_sub != 2'd0));

    // A commit coincides with the start of the data ACK
    assert_commit_with_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (sda_oe_o && !$past(sda_oe_o)));

    // Without a commit the stored settings stay put
    assert_hold_without_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(cutoff_code_o) && $stable(ch_type_o) &&
                     $stable(filt_bypass_o) && $stable(pwr_down_o)));

endmodule

bind vfe_ctl_slave vfe_ctl_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .wr_stb(wr_stb), .wr_sub(wr_sub), .cutoff_code_o(cutoff_code_o),
    .ch_type_o(ch_type_o), .ch_half_o(ch_half_o),
    .filt_bypass_o(filt_bypass_o), .pwr_down_o(pwr_down_o)
);

// File: tb/vfe_ctl_slave_tb.sv
// Bench: bit-level bus master, register model and output comparison.
module vfe_ctl_slave_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic mux_pin = 1'b0;
    logic sda_oe;
    logic [7:0] cut_o;
    logic [5:0] type_o;
    logic [2:0] half_o;
    logic byp_o, pd_o, selb_o;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0] m_addr;
    logic [7:0] m_cut;
    logic [5:0] m_kind;
    logic m_pd, m_mux, m_half, m_byp;

    always #5 clk = ~clk;

    vfe_ctl_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .mux_pin_i(mux_pin),
        .cutoff_code_o(cut_o), .ch_type_o(type_o), .ch_half_o(half_o),
        .filt_bypass_o(byp_o), .pwr_down_o(pd_o), .sel_b_o(selb_o)
    );

    function automatic logic [6:0] addr_of(input logic [1:0] s);
        return s[1] ? 7'h4A : (s[0] ? 7'h49 : 7'h48);
    endfunction

    function automatic logic [19:0] expected();
        logic [5:0] t;
        logic [2:0] h;
        for (int c = 0; c < 3; c++) begin
            logic [1:0] f;
            f = m_kind[5-2*c -: 2];
            t[2*c +: 2] = f[1] ? 2'b10 : (f[0] ? 2'b01 : 2'b00);
        end
        h = {m_half & ~m_byp, m_half & ~m_byp, 1'b0};
        return {m_cut, t, h, m_byp, m_pd, mux_pin | m_mux};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req);
        chk(req, "outputs", 32'({cut_o, type_o, half_o, byp_o, pd_o, selb_o}), 32'(expected()));
    endtask

    task automatic hq(input int n = 1);
        repeat (n*Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq; scl_m = 1'b1; hq; sda_m = 1'b0; hq; scl_m = 1'b0; hq;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq; scl_m = 1'b1; hq; sda_m = 1'b1; hq(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hq; scl_m = 1'b1; hq(2); scl_m = 1'b0; hq;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        send_bits(b, 8);
        sda_m = 1'b1; hq; scl_m = 1'b1; hq; nack = sda_line; hq; scl_m = 1'b0; hq;
    endtask

    task automatic do_reset(input logic [1:0] s);
        strap = s;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        m_addr = addr_of(s);
        m_cut = 8'h7D; m_kind = '0;
        m_pd = 0; m_mux = 0; m_half = 0; m_byp = 0;
    endtask

    function automatic void model_write(input logic [7:0] s, input logic [7:0] d);
        case (s)
            8'h01: m_cut = d;
            8'h02: m_kind = d[7:2];
            8'h03: begin m_pd = d[7]; m_mux = d[6]; m_half = d[5]; m_byp = d[4]; end
            default: ;
        endcase
    endfunction

    // Full frame with ACK expectations derived from the model
    task automatic run_frame(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d, input string req);
        logic n;
        bit ek0, ek1;
        ek0 = (a == {m_addr, 1'b0});
        ek1 = ek0 && (s >= 8'h01) && (s <= 8'h03);
        bus_start();
        send_byte(a, n);
        chk(ek0 ? "R2" : req, "address ack", 32'(n), 32'(!ek0));
        if (!n) begin
            send_byte(s, n);
            chk(ek1 ? "R3" : req, "selector ack", 32'(n), 32'(!ek1));
            if (!n) begin
                if (ek1) model_write(s, d);
                send_byte(d, n);
                chk("R4", "data ack", 32'(n), 32'(0));
                chk_out("R12");
            end
        end
        bus_stop();
        chk_out(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic n;
        void'($urandom(32'd5150));
        do_reset(2'b00);
        chk_out("R1");
        mux_pin = 1'b1; @(negedge clk); chk_out("R8");
        mux_pin = 1'b0; @(negedge clk); chk_out("R8");

        run_frame(8'h90, 8'h01, 8'hA5, "R5");
        run_frame(8'h92, 8'h01, 8'h11, "R2");
        run_frame(8'h91, 8'h01, 8'h22, "R2");
        run_frame(8'h90, 8'h04, 8'h33, "R3");
        run_frame(8'h90, 8'h00, 8'h44, "R3");
        run_frame(8'h90, 8'h02, 8'b10_01_00_11, "R6");
        run_frame(8'h90, 8'h02, 8'b11_00_01_00, "R6");
        run_frame(8'h90, 8'h03, 8'hFF, "R7");
        chk("R9", "half with bypass", 32'(half_o), 32'(0));
        run_frame(8'h90, 8'h03, 8'h20, "R9");
        chk("R9", "half no bypass", 32'(half_o), 32'(3'b110));
        run_frame(8'h90, 8'h03, 8'h40, "R8");
        mux_pin = 1'b1; @(negedge clk); chk_out("R8");
        run_frame(8'h90, 8'h03, 8'h0F, "R7");
        chk_out("R8");
        mux_pin = 1'b0; @(negedge clk); chk_out("R8");

        // Abort with stop in the middle of the data byte
        bus_start(); send_byte(8'h90, n); send_byte(8'h01, n);
        send_bits(8'h3C, 4); bus_stop();
        chk_out("R10");
        // Abort with repeated start, then a fresh good frame
        bus_start(); send_byte(8'h90, n); send_byte(8'h02, n);
        send_bits(8'hFC, 5); sda_m = 1'b1; hq;
        chk_out("R10");
        run_frame(8'h90, 8'h01, 8'h80, "R10");
        // Abort with stop right after the selector
        bus_start(); send_byte(8'h90, n); send_byte(8'h03, n); bus_stop();
        chk_out("R10");

        // Trailing byte after the data byte
        bus_start(); send_byte(8'h90, n); send_byte(8'h01, n);
        model_write(8'h01, 8'h5A);
        send_byte(8'h5A, n); send_byte(8'h03, n);
        chk("R11", "fourth byte ack", 32'(n), 32'(1));
        send_byte(8'hF0, n); bus_stop();
        chk_out("R11");

        // Strap change after reset is ignored
        strap = 2'b01; repeat (4) @(negedge clk);
        run_frame(8'h90, 8'h01, 8'h12, "R13");
        run_frame(8'h92, 8'h01, 8'h34, "R13");

        do_reset(2'b01); chk_out("R1");
        run_frame(8'h92, 8'h01, 8'h07, "R2");
        run_frame(8'h90, 8'h01, 8'h08, "R2");
        do_reset(2'b10);
        run_frame(8'h94, 8'h03, 8'hA0, "R2");
        do_reset(2'b11);
        run_frame(8'h94, 8'h02, 8'h54, "R2");
        run_frame(8'h95, 8'h02, 8'hFC, "R2");

        // Constrained random frames
        for (int k = 0; k < 40; k++) begin
            logic [7:0] a, s, d;
            a = ($urandom % 4 == 0) ? 8'($urandom) : {m_addr, 1'b0};
            s = 8'($urandom_range(0, 4));
            d = 8'($urandom);
            mux_pin = 1'($urandom);
            run_frame(a, s, d, (s == 8'h01) ? "R5" : (s == 8'h02) ? "R6" : (s == 8'h03) ? "R7" : "R3");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule